// File: doc/BRIEF.md
# Dual Down-Counting Timer with Auto-Reload

This peripheral holds two independent 32-bit counters that step down by one on every cycle in which the shared tick enable is high. Software reaches it through a single-cycle register bus. Writes take effect at the clock edge of the write cycle. Reads are combinational from the address and are valid in the same cycle.

Each counter runs in one of two modes. In one-shot mode it stops at zero and turns itself off. In periodic mode it refills from its own reload register and keeps running. Every time a counter passes through zero it latches a per-timer cause bit. A per-timer mask bit then decides whether that cause drives the matching interrupt line.

The register layout is:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | cause |
| 0x08 | mask |
| 0x10 + 8·t | reload of timer t |
| 0x14 + 8·t | live count of timer t |

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every register reads as zero and both interrupt outputs are low.
- R2: Control bit 2t enables timer t and bit 2t+1 selects auto-reload for it. An enabled timer with a nonzero count decrements by one in each cycle where `tick_en` is high. A disabled timer holds its count.
- R3: With auto-reload on, a tick that finds the count at zero signals an expiry and loads the old reload value, so a reload value N gives a period of N+1 ticks.
- R4: With auto-reload off, a tick that finds the count at zero signals exactly one expiry, holds the count at zero and clears the enable bit. A control write in that same cycle wins over this clear.
- R5: A write to a live-count register replaces the count at that edge, overriding any decrement or expiry of that cycle, and leaves the reload register untouched.
- R6: An expiry sets cause bit t (offset 0x04). Writing 0 to a cause bit clears it and writing 1 leaves it as it is. An expiry in the same cycle as a clear leaves the bit set.
- R7: `irq_o[t]` is high exactly when cause bit t and mask bit t (offset 0x08) are both set.
- R8: Reads of unmapped offsets, including unaligned ones, return zero. Writes to them change nothing. `bus_rdata` is zero while `bus_sel` is low.
- R9: The count spans the full 32 bits with no truncation, so a count started at 0xFFFFFFFF reads 0xFFFFFFFF minus the elapsed ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable shared by both timers |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 2 | Masked interrupt per timer |

## Verification
A wrong count or a missed reload shows up at the next live-count read and, one period later, as a shifted or missing interrupt edge. A cause bit that is lost or set twice changes `irq_o` in the cycle right after the faulty edge. The bench therefore compares the interrupt lines against its behavioural model on every clock and reads the registers back at the points where collisions (write against expiry, clear against expiry) were just forced.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
   localparam int OFF_CTRL  = 'h00;
   localparam int OFF_CAUSE = 'h04;
   localparam int OFF_MASK  = 'h08;
   localparam int OFF_TBASE = 'h10;
   localparam int OFF_TSTEP = 'h08;

   function automatic int reload_off(input int t);
      return OFF_TBASE + OFF_TSTEP * t;
   endfunction

   function automatic int value_off(input int t);
      return OFF_TBASE + OFF_TSTEP * t + 4;
   endfunction

   typedef struct packed {
      logic auto_rld;
      logic run;
   } tmr_mode_t;
endpackage

// File: rtl/dtt_counter.sv
module dtt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  dtt_pkg::tmr_mode_t mode,
   input  logic [CNT_W-1:0] rld_val,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] count,
   output logic             expire,
   output logic             stop
);
   logic at_zero;

   assign at_zero = (count == '0);
   assign expire  = tick & mode.run & at_zero & ~ld_we;
   assign stop    = expire & ~mode.auto_rld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (ld_we) begin
         count <= ld_val;
      end else if (tick && mode.run) begin
         if (!at_zero) begin
            count <= count - 1'b1;
         end else if (mode.auto_rld) begin
            count <= rld_val;
         end
      end
   end
endmodule

// File: rtl/dtt_cause.sv
module dtt_cause #(
   parameter int N_TMR = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_TMR-1:0] expire,
   input  logic             ack_we,
   input  logic [N_TMR-1:0] ack_bits,
   input  logic [N_TMR-1:0] mask,
   output logic [N_TMR-1:0] cause,
   output logic [N_TMR-1:0] irq
);
   logic [N_TMR-1:0] kept;

   assign kept = ack_we ? (cause & ack_bits) : cause;

   always_ff @(posedge clk) begin
      if (!rst_n) cause <= '0;
      else        cause <= kept | expire;
   end

   assign irq = cause & mask;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
   parameter int N_TMR  = 2,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_TMR-1:0]  irq_o
);
   import dtt_pkg::*;

   localparam int CTRL_W  = 2 * N_TMR;
   localparam int MAX_OFF = value_off(N_TMR - 1);

   if (N_TMR < 1 || N_TMR > 4) begin : g_err_ntmr
      $error("N_TMR must lie in 1..4");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_err_cntw
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_err_dataw
      $error("DATA_W too narrow for the control word");
   end
   if (MAX_OFF >= (1 << ADDR_W)) begin : g_err_addrw
      $error("ADDR_W too narrow for the register map");
   end

   logic                wr_hit, ctrl_we, cause_we, mask_we;
   logic [CTRL_W-1:0]   ctrl_q, stop_mask;
   logic [N_TMR-1:0]    mask_q, cause_q, expire, stop, ld_we, rld_we;
   logic [CNT_W-1:0]    reload_q [N_TMR];
   logic [CNT_W-1:0]    count_q  [N_TMR];

   assign wr_hit   = bus_sel & bus_wr;
   assign ctrl_we  = wr_hit && (bus_addr == ADDR_W'(OFF_CTRL));
   assign cause_we = wr_hit && (bus_addr == ADDR_W'(OFF_CAUSE));
   assign mask_we  = wr_hit && (bus_addr == ADDR_W'(OFF_MASK));

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      tmr_mode_t mode;

      assign mode.run      = ctrl_q[2*t];
      assign mode.auto_rld = ctrl_q[2*t+1];
      assign rld_we[t] = wr_hit && (bus_addr == ADDR_W'(reload_off(t)));
      assign ld_we[t]  = wr_hit && (bus_addr == ADDR_W'(value_off(t)));

      always_ff @(posedge clk) begin
         if (!rst_n)         reload_q[t] <= '0;
         else if (rld_we[t]) reload_q[t] <= bus_wdata[CNT_W-1:0];
      end

      dtt_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick_en),
         .mode    (mode),
         .rld_val (reload_q[t]),
         .ld_we   (ld_we[t]),
         .ld_val  (bus_wdata[CNT_W-1:0]),
         .count   (count_q[t]),
         .expire  (expire[t]),
         .stop    (stop[t])
      );
   end

   always_comb begin
      for (int t = 0; t < N_TMR; t++) begin
         stop_mask[2*t]   = stop[t];
         stop_mask[2*t+1] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= bus_wdata[CTRL_W-1:0];
      else              ctrl_q <= ctrl_q & ~stop_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= bus_wdata[N_TMR-1:0];
   end

   dtt_cause #(.N_TMR(N_TMR)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .ack_we   (cause_we),
      .ack_bits (bus_wdata[N_TMR-1:0]),
      .mask     (mask_q),
      .cause    (cause_q),
      .irq      (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (bus_addr == ADDR_W'(OFF_CTRL))  bus_rdata[CTRL_W-1:0] = ctrl_q;
         if (bus_addr == ADDR_W'(OFF_CAUSE)) bus_rdata[N_TMR-1:0]  = cause_q;
         if (bus_addr == ADDR_W'(OFF_MASK))  bus_rdata[N_TMR-1:0]  = mask_q;
         for (int t = 0; t < N_TMR; t++) begin
            if (bus_addr == ADDR_W'(reload_off(t))) bus_rdata[CNT_W-1:0] = reload_q[t];
            if (bus_addr == ADDR_W'(value_off(t)))  bus_rdata[CNT_W-1:0] = count_q[t];
         end
      end
   end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
   parameter int N_TMR = 2,
   parameter int CNT_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_en,
   input logic [2*N_TMR-1:0]   ctrl_q,
   input logic                 ctrl_we,
   input logic                 cause_we,
   input logic [N_TMR-1:0]     ack_bits,
   input logic [N_TMR-1:0]     cause_q,
   input logic [N_TMR-1:0]     expire,
   input logic [N_TMR-1:0]     ld_we,
   input logic [CNT_W-1:0]     count_q  [N_TMR],
   input logic [CNT_W-1:0]     reload_q [N_TMR]
);
   for (genvar t = 0; t < N_TMR; t++) begin : g_chk
      AST_DECREMENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         tick_en && ctrl_q[2*t] && !ld_we[t] && (count_q[t] != '0)
         |=> count_q[t] == CNT_W'($past(count_q[t]) - 1'b1)); // R2

      AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[2*t] && !ld_we[t] |=> $stable(count_q[t])); // R2

      AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         expire[t] && ctrl_q[2*t+1] |=> count_q[t] == $past(reload_q[t])); // R3

      AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
         expire[t] && !ctrl_q[2*t+1] && !ctrl_we
         |=> !ctrl_q[2*t] && (count_q[t] == '0)); // R4

      AST_EXPIRY_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         expire[t] |=> cause_q[t]); // R6

      AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         cause_we && !ack_bits[t] && !expire[t] |=> !cause_q[t]); // R6
   end
endmodule

bind dual_tick_timer dtt_checker #(.N_TMR(N_TMR), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .ctrl_q   (ctrl_q),
   .ctrl_we  (ctrl_we),
   .cause_we (cause_we),
   .ack_bits (bus_wdata[N_TMR-1:0]),
   .cause_q  (cause_q),
   .expire   (expire),
   .ld_we    (ld_we),
   .count_q  (count_q),
   .reload_q (reload_q)
);

// File: tb/tb_dual_tick_timer.sv
`timescale 1ns/1ps
module tb_dual_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   dual_tick_timer dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // behavioural reference model
   logic [3:0]  m_ctrl;
   logic [1:0]  m_cause, m_mask, m_ex;
   logic [31:0] m_rld [2];
   logic [31:0] m_val [2];
   logic [3:0]  m_nc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_cause = '0; m_mask = '0;
         m_rld[0] = '0; m_rld[1] = '0; m_val[0] = '0; m_val[1] = '0;
      end else begin
         m_ex = '0;
         m_nc = m_ctrl;
         for (int t = 0; t < 2; t++) begin
            if (bus_sel && bus_wr && bus_addr == 8'(20 + 8*t)) begin
               m_val[t] = bus_wdata;
            end else if (tick_en && m_ctrl[2*t]) begin
               if (m_val[t] == 0) begin
                  m_ex[t] = 1'b1;
                  if (m_ctrl[2*t+1]) m_val[t] = m_rld[t];
                  else               m_nc[2*t] = 1'b0;
               end else begin
                  m_val[t] = m_val[t] - 1;
               end
            end
            if (bus_sel && bus_wr && bus_addr == 8'(16 + 8*t)) m_rld[t] = bus_wdata;
         end
         if (bus_sel && bus_wr && bus_addr == 8'h00) m_nc = bus_wdata[3:0];
         m_ctrl = m_nc;
         if (bus_sel && bus_wr && bus_addr == 8'h08) m_mask = bus_wdata[1:0];
         if (bus_sel && bus_wr && bus_addr == 8'h04) m_cause = m_cause & bus_wdata[1:0];
         m_cause = m_cause | m_ex;
      end
   end

   function automatic logic [31:0] model_rd(input logic [7:0] a);
      case (a)
         8'h00: return {28'd0, m_ctrl};
         8'h04: return {30'd0, m_cause};
         8'h08: return {30'd0, m_mask};
         8'h10: return m_rld[0];
         8'h14: return m_val[0];
         8'h18: return m_rld[1];
         8'h1C: return m_val[1];
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R7: interrupt lines compared against the model every cycle
   always @(negedge clk) begin
      if (rst_n && !done)
         check(irq_o == (m_cause & m_mask), "R7 per-cycle irq",
               {30'd0, irq_o}, {30'd0, m_cause & m_mask});
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      check(bus_rdata == exp, tag, bus_rdata, exp);
      check(bus_rdata == model_rd(a), {tag, " model"}, bus_rdata, model_rd(a));
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic run(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick_en = 1'b0;
   endtask

   task automatic irq_is(input logic [1:0] exp, input string tag);
      @(negedge clk); #1;
      check(irq_o == exp, tag, {30'd0, irq_o}, {30'd0, exp});
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      irq_is(2'b00, "R1 irq after reset");
      rd(8'h00, 0, "R1 ctrl"); rd(8'h04, 0, "R1 cause"); rd(8'h08, 0, "R1 mask");
      rd(8'h10, 0, "R1 reload0"); rd(8'h14, 0, "R1 value0");
      rd(8'h18, 0, "R1 reload1"); rd(8'h1C, 0, "R1 value1");

      // R8 unmapped and unaligned offsets
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, 0, "R8 unmapped 0x0C"); rd(8'h20, 0, "R8 unmapped 0x20");
      rd(8'h01, 0, "R8 unaligned 0x01");
      @(negedge clk); bus_addr = 8'h14; #1;
      check(bus_rdata == 0, "R8 rdata idle", bus_rdata, 0);

      // R3 periodic timer 0, reload 3 -> period 4
      wr(8'h10, 3); wr(8'h14, 3); wr(8'h08, 1); wr(8'h00, 4'b0011);
      run(4);
      rd(8'h14, 3, "R3 reloaded after 4 ticks");
      rd(8'h04, 1, "R6 cause set by expiry");
      irq_is(2'b01, "R7 irq with mask");
      run(2);
      rd(8'h14, 1, "R2 decrement");

      // R2 disabled timer holds
      wr(8'h00, 0);
      held = model_rd(8'h14);
      run(5);
      rd(8'h14, held, "R2 disabled holds");

      // R6 zero clears, one keeps
      wr(8'h04, 32'h2);
      rd(8'h04, 0, "R6 write zero clears");
      irq_is(2'b00, "R7 irq after ack");

      // R4 one-shot timer 1
      wr(8'h1C, 5); wr(8'h00, 4'b0100);
      run(5);
      rd(8'h04, 0, "R4 no expiry before zero");
      run(1);
      rd(8'h1C, 0, "R4 holds zero");
      rd(8'h00, 0, "R4 enable cleared");
      rd(8'h04, 2, "R4 cause bit1");
      irq_is(2'b00, "R7 masked timer1");
      wr(8'h04, 0);
      run(10);
      rd(8'h04, 0, "R4 single expiry");

      // R5 value write collides with zero-count tick
      wr(8'h1C, 0); wr(8'h00, 4'b0100);
      @(negedge clk);
      tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 7;
      @(posedge clk); #1;
      tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h1C, 7, "R5 write replaces count");
      rd(8'h04, 0, "R5 no expiry signalled");
      rd(8'h18, 0, "R5 reload untouched");
      rd(8'h00, 4, "R5 still enabled");
      run(3);
      rd(8'h1C, 4, "R2 three ticks");
      repeat (3) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
      end
      rd(8'h1C, 1, "R2 sparse ticks");
      wr(8'h00, 0);

      // R6 expiry wins over a clear in the same cycle
      wr(8'h14, 0); wr(8'h00, 4'b0001);
      @(negedge clk);
      tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 0;
      @(posedge clk); #1;
      tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h04, 1, "R6 expiry beats clear");
      rd(8'h00, 0, "R4 timer0 enable cleared");
      wr(8'h04, 32'h1);
      rd(8'h04, 1, "R6 write one keeps");

      // R7 mask gating
      irq_is(2'b01, "R7 cause and mask");
      wr(8'h08, 0);
      irq_is(2'b00, "R7 mask off");
      wr(8'h08, 1);
      irq_is(2'b01, "R7 mask back on");
      wr(8'h04, 0);
      irq_is(2'b00, "R7 cleared");

      // R3 timer 1 periodic with reload 1
      wr(8'h18, 1); wr(8'h1C, 1); wr(8'h08, 2); wr(8'h00, 4'b1100);
      run(2);
      rd(8'h1C, 1, "R3 timer1 reload");
      rd(8'h04, 2, "R3 timer1 cause");
      irq_is(2'b10, "R7 timer1 irq");
      wr(8'h00, 0); wr(8'h04, 0);

      // R9 full-width count
      wr(8'h14, 32'hFFFF_FFFF); wr(8'h00, 4'b0001);
      run(5);
      rd(8'h14, 32'hFFFF_FFFA, "R9 elapsed from all ones");
      wr(8'h14, 32'hFFFF_FFFE);
      rd(8'h14, 32'hFFFF_FFFE, "R9 largest one-shot");
      run(1);
      rd(8'h14, 32'hFFFF_FFFD, "R9 first tick");
      wr(8'h00, 0);

      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule